// File: doc/BRIEF.md
# End-of-Interrupt Release Engine with Storm Throttling

This block takes an end-of-interrupt vector and visits every redirection entry of an interrupt table, one pin per clock, looking for entries in level mode that carry that vector. For each such entry whose remote in-service flag is set, it pulses a clear strobe toward the table. If the released pin is unmasked and still pending, the interrupt fires again at once, and the block asks for a new service scan.

A guest that never quiets a level source would keep this loop spinning. To stop that, the block keeps a count for each pin of how many releases in a row found the pin still live. When a count reaches a threshold, the count returns to zero. The immediate request is then replaced by one delayed request, produced by a single timer. While the timer is armed, further throttle requests are absorbed, so the existing deadline never moves later.

The vector input is a valid/ready stream. A vector is taken on a clock edge where `eoi_valid` and `eoi_ready` are both high. `eoi_ready` then stays low for exactly NUM_PINS cycles while the walk runs, and the source must hold its vector until it is taken. The table interface, the software write notice and the service request are plain signals.

Top module: `eoi_storm_ctrl`

## Requirements
- R1: After reset, `eoi_ready` is 1, `svc_req` is 0 and `clr_rirr` is 0.
- R2: A vector is accepted on an edge where `eoi_valid` and `eoi_ready` are both 1. Over the next NUM_PINS cycles, `eoi_ready` is 0 and `tbl_idx` steps through 0, 1, …, NUM_PINS-1, one value per cycle. `eoi_ready` is 1 again in the cycle after that.
- R3: An entry is a candidate only if `tbl_vector` equals the accepted vector and `tbl_level` is 1. Any other entry gets no clear strobe and causes no request.
- R4: A candidate with `tbl_rirr`=1 gets `clr_rirr`=1 in the cycle it is visited. A candidate with `tbl_rirr`=0 gets no strobe and no request, and its pin count is left unchanged.
- R5: A released candidate (flag was set) that has `tbl_masked`=0 and `tbl_pend`=1, and whose count plus one is below THRESH, increments its count. `svc_req` is then 1 in the cycle after its visit cycle.
- R6: A released candidate that is masked or not pending resets its count to 0 and raises no request.
- R7: A released, unmasked, pending candidate whose count plus one reaches THRESH resets its count to 0 and raises no immediate request. Instead, `svc_req` pulses for one cycle DELAY cycles after the point where the immediate request would have appeared.
- R8: A cycle with `cfg_wr_valid`=1 resets the count of pin `cfg_wr_pin` to 0.
- R9: While the delay timer is armed, a further throttle request leaves the deadline unchanged and adds no extra pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| eoi_valid | input | 1 | End-of-interrupt vector offered |
| eoi_ready | output | 1 | Engine idle, vector can be taken |
| eoi_vector | input | VEC_W | Vector being retired |
| tbl_idx | output | PIN_W | Entry currently visited |
| tbl_vector | input | VEC_W | Vector field of the visited entry |
| tbl_level | input | 1 | 1 = level mode for the visited entry |
| tbl_masked | input | 1 | Mask bit of the visited entry |
| tbl_rirr | input | 1 | Remote in-service flag of the visited entry |
| tbl_pend | input | 1 | Pending bit of the visited pin |
| clr_rirr | output | 1 | Clear the visited entry's in-service flag |
| cfg_wr_valid | input | 1 | Software wrote an entry |
| cfg_wr_pin | input | PIN_W | Pin of the written entry |
| svc_req | output | 1 | Service scan request pulse |

## Verification
On every cycle, the assertions check the walk handshake. They confirm that ready drops after an accept, that the index advances by one while busy, that clear strobes appear only on visited entries in level mode with their flag set, that every request comes from a walk or from the armed timer, and that the timer's expiry always yields a pulse. Some behaviour depends on history across several vectors: the exact cycle of immediate and delayed pulses, counts reset by masked or idle releases and by software writes, counts left alone by entries whose flag is clear, and a second throttle absorbed while the timer is armed. Only the bench's scenarios can show these.

// File: rtl/eoi_pkg.sv
package eoi_pkg;
  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_BUSY = 1'b1
  } walk_state_t;
endpackage

// File: rtl/eoi_walker.sv
module eoi_walker #(
  parameter int NUM_PINS = 24,
  parameter int VEC_W    = 8,
  localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eoi_valid,
  input  logic [VEC_W-1:0] eoi_vector,
  output logic             eoi_ready,
  output logic             walk_active,
  output logic [PIN_W-1:0] walk_pin,
  output logic [VEC_W-1:0] walk_vec
);
  import eoi_pkg::*;

  localparam logic [PIN_W-1:0] LAST_PIN = PIN_W'(NUM_PINS - 1);

  walk_state_t state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= WALK_IDLE;
      walk_pin <= '0;
      walk_vec <= '0;
    end else begin
      case (state_q)
        WALK_IDLE: begin
          if (eoi_valid) begin
            state_q  <= WALK_BUSY;
            walk_pin <= '0;
            walk_vec <= eoi_vector;
          end
        end
        default: begin
          if (walk_pin == LAST_PIN) begin
            state_q <= WALK_IDLE;
          end else begin
            walk_pin <= walk_pin + 1'b1;
          end
        end
      endcase
    end
  end

  assign eoi_ready   = (state_q == WALK_IDLE);
  assign walk_active = (state_q == WALK_BUSY);
endmodule

// File: rtl/storm_counters.sv
module storm_counters #(
  parameter int NUM_PINS = 24,
  parameter int THRESH   = 10000,
  localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  localparam int CNT_W   = $clog2(THRESH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rel_valid,
  input  logic [PIN_W-1:0] rel_pin,
  input  logic             rel_live,
  input  logic             cfg_wr_valid,
  input  logic [PIN_W-1:0] cfg_wr_pin,
  output logic             req_now,
  output logic             req_later
);
  localparam logic [CNT_W:0] LIMIT = (CNT_W + 1)'(THRESH);

  logic [CNT_W-1:0] cnt_q [NUM_PINS];
  logic [CNT_W:0]   cnt_next;
  logic             at_limit;

  assign cnt_next = {1'b0, cnt_q[rel_pin]} + 1'b1;
  assign at_limit = (cnt_next >= LIMIT);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic hit_rel;
    logic hit_cfg;
    assign hit_rel = rel_valid && (rel_pin == PIN_W'(p));
    assign hit_cfg = cfg_wr_valid && (cfg_wr_pin == PIN_W'(p));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[p] <= '0;
      end else if (hit_cfg) begin
        cnt_q[p] <= '0;
      end else if (hit_rel) begin
        if (rel_live && !at_limit) begin
          cnt_q[p] <= cnt_next[CNT_W-1:0];
        end else begin
          cnt_q[p] <= '0;
        end
      end
    end
  end

  assign req_now   = rel_valid && rel_live && !at_limit;
  assign req_later = rel_valid && rel_live && at_limit;
endmodule

// File: rtl/reservice_timer.sv
module reservice_timer #(
  parameter int DELAY  = 100000,
  localparam int REM_W = $clog2(DELAY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sched,
  output logic armed,
  output logic fire
);
  logic [REM_W-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      rem_q <= '0;
      fire  <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (!armed) begin
        if (sched) begin
          armed <= 1'b1;
          rem_q <= REM_W'(DELAY);
        end
      end else if (rem_q == REM_W'(1)) begin
        armed <= 1'b0;
        fire  <= 1'b1;
      end else begin
        rem_q <= rem_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/eoi_storm_ctrl.sv
module eoi_storm_ctrl #(
  parameter int NUM_PINS = 24,
  parameter int VEC_W    = 8,
  parameter int THRESH   = 10000,
  parameter int DELAY    = 100000,
  localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eoi_valid,
  output logic             eoi_ready,
  input  logic [VEC_W-1:0] eoi_vector,
  output logic [PIN_W-1:0] tbl_idx,
  input  logic [VEC_W-1:0] tbl_vector,
  input  logic             tbl_level,
  input  logic             tbl_masked,
  input  logic             tbl_rirr,
  input  logic             tbl_pend,
  output logic             clr_rirr,
  input  logic             cfg_wr_valid,
  input  logic [PIN_W-1:0] cfg_wr_pin,
  output logic             svc_req
);
  logic             walk_active;
  logic [VEC_W-1:0] walk_vec;
  logic             release_hit;
  logic             req_now;
  logic             req_later;
  logic             timer_armed;
  logic             timer_fire;
  logic             imm_q;

  eoi_walker #(.NUM_PINS(NUM_PINS), .VEC_W(VEC_W)) u_walker (
    .clk        (clk),
    .rst_n      (rst_n),
    .eoi_valid  (eoi_valid),
    .eoi_vector (eoi_vector),
    .eoi_ready  (eoi_ready),
    .walk_active(walk_active),
    .walk_pin   (tbl_idx),
    .walk_vec   (walk_vec)
  );

  // released = visited, level mode, vector match, flag set
  assign release_hit = walk_active && tbl_level && tbl_rirr &&
                       (tbl_vector == walk_vec);
  assign clr_rirr = release_hit;

  storm_counters #(.NUM_PINS(NUM_PINS), .THRESH(THRESH)) u_counters (
    .clk         (clk),
    .rst_n       (rst_n),
    .rel_valid   (release_hit),
    .rel_pin     (tbl_idx),
    .rel_live    (!tbl_masked && tbl_pend),
    .cfg_wr_valid(cfg_wr_valid),
    .cfg_wr_pin  (cfg_wr_pin),
    .req_now     (req_now),
    .req_later   (req_later)
  );

  reservice_timer #(.DELAY(DELAY)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .sched(req_later),
    .armed(timer_armed),
    .fire (timer_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) imm_q <= 1'b0;
    else        imm_q <= req_now;
  end

  assign svc_req = imm_q || timer_fire;
endmodule

// File: rtl/eoi_storm_ctrl_chk.sv
module eoi_storm_ctrl_chk #(
  parameter int PIN_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             eoi_valid,
  input logic             eoi_ready,
  input logic [PIN_W-1:0] tbl_idx,
  input logic             tbl_level,
  input logic             tbl_rirr,
  input logic             clr_rirr,
  input logic             svc_req,
  input logic             timer_armed
);
  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && eoi_ready) |=> !eoi_ready);

  p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!eoi_ready && $past(!eoi_ready)) |-> (tbl_idx == PIN_W'($past(tbl_idx) + 1'b1)));

  p_clr_only_flagged_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_rirr |-> (!eoi_ready && tbl_level && tbl_rirr));

  p_req_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> ($past(!eoi_ready) || $past(timer_armed)));

  p_expiry_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(timer_armed) |-> svc_req);
endmodule

bind eoi_storm_ctrl eoi_storm_ctrl_chk #(.PIN_W(PIN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .eoi_valid  (eoi_valid),
  .eoi_ready  (eoi_ready),
  .tbl_idx    (tbl_idx),
  .tbl_level  (tbl_level),
  .tbl_rirr   (tbl_rirr),
  .clr_rirr   (clr_rirr),
  .svc_req    (svc_req),
  .timer_armed(timer_armed)
);

// File: tb/eoi_storm_ctrl_bench.sv
`timescale 1ns/1ps
module eoi_storm_ctrl_bench;
  localparam int NP    = 8;
  localparam int PW    = 3;
  localparam int THR   = 3;
  localparam int DLY   = 20;
  localparam int WIN   = NP + DLY + 6;
  localparam logic [7:0] VEC  = 8'h31;
  localparam logic [7:0] OTHV = 8'h10;
  localparam int PIN_A = 4;
  localparam int PIN_B = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic eoi_valid = 1'b0;
  logic eoi_ready;
  logic [7:0] eoi_vector = '0;
  logic [PW-1:0] tbl_idx;
  logic [7:0] tbl_vector;
  logic tbl_level, tbl_masked, tbl_rirr, tbl_pend;
  logic clr_rirr;
  logic cfg_wr_valid = 1'b0;
  logic [PW-1:0] cfg_wr_pin = '0;
  logic svc_req;

  logic [7:0] t_vec [NP];
  logic t_lvl [NP];
  logic t_msk [NP];
  logic t_rirr [NP];
  logic t_pend [NP];

  int n_checks = 0;
  int n_fails = 0;
  bit hit [WIN];
  bit clr_hit [NP];
  bit hs_ok;

  always #2.5 clk = ~clk;

  eoi_storm_ctrl #(.NUM_PINS(NP), .VEC_W(8), .THRESH(THR), .DELAY(DLY)) u_eoi_storm_ctrl (
    .clk(clk), .rst_n(rst_n), .eoi_valid(eoi_valid), .eoi_ready(eoi_ready),
    .eoi_vector(eoi_vector), .tbl_idx(tbl_idx), .tbl_vector(tbl_vector),
    .tbl_level(tbl_level), .tbl_masked(tbl_masked), .tbl_rirr(tbl_rirr),
    .tbl_pend(tbl_pend), .clr_rirr(clr_rirr), .cfg_wr_valid(cfg_wr_valid),
    .cfg_wr_pin(cfg_wr_pin), .svc_req(svc_req)
  );

  assign tbl_vector = t_vec[tbl_idx];
  assign tbl_level  = t_lvl[tbl_idx];
  assign tbl_masked = t_msk[tbl_idx];
  assign tbl_rirr   = t_rirr[tbl_idx];
  assign tbl_pend   = t_pend[tbl_idx];

  always @(posedge clk) if (clr_rirr) t_rirr[tbl_idx] <= 1'b0;

  // row bits: {lvl, msk, rirr, pend, match, exp_clr, exp_imm}
  localparam logic [6:0] ROWS [6] = '{
    7'b1011111, 7'b1111110, 7'b1010110,
    7'b1001100, 7'b0011100, 7'b1011000
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic table_default();
    for (int p = 0; p < NP; p++) begin
      t_vec[p] = OTHV; t_lvl[p] = 1'b1; t_msk[p] = 1'b0;
      t_rirr[p] = 1'b1; t_pend[p] = 1'b1;
    end
  endtask

  task automatic sw_write(input int pin);
    @(negedge clk);
    cfg_wr_valid = 1'b1; cfg_wr_pin = PW'(pin);
    @(negedge clk);
    cfg_wr_valid = 1'b0;
  endtask

  task automatic run_eoi(input logic [7:0] v);
    for (int k = 0; k < WIN; k++) hit[k] = 1'b0;
    for (int p = 0; p < NP; p++) clr_hit[p] = 1'b0;
    hs_ok = 1'b1;
    @(negedge clk);
    eoi_valid = 1'b1; eoi_vector = v;
    @(posedge clk);
    #1 eoi_valid = 1'b0;
    for (int k = 0; k < WIN; k++) begin
      @(negedge clk);
      if (svc_req) hit[k] = 1'b1;
      if (k < NP) begin
        if (eoi_ready !== 1'b0 || tbl_idx !== PW'(k)) hs_ok = 1'b0;
        if (clr_rirr) clr_hit[tbl_idx] = 1'b1;
      end else if (k == NP) begin
        if (eoi_ready !== 1'b1) hs_ok = 1'b0;
      end
    end
  endtask

  function automatic int pulse_count();
    int c = 0;
    for (int k = 0; k < WIN; k++) c += int'(hit[k]);
    return c;
  endfunction

  initial begin
    #(200000 * 5);
    n_fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    table_default();
    #12;
    check(eoi_ready === 1'b1 && svc_req === 1'b0 && clr_rirr === 1'b0, "R1 reset outputs",
          int'({eoi_ready, svc_req, clr_rirr}), 3'b100);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(eoi_ready === 1'b1 && svc_req === 1'b0, "R1 after release",
          int'({eoi_ready, svc_req}), 2'b10);

    // table-driven single-entry scenarios on PIN_A
    for (int r = 0; r < 6; r++) begin
      table_default();
      t_lvl[PIN_A]  = ROWS[r][6];
      t_msk[PIN_A]  = ROWS[r][5];
      t_rirr[PIN_A] = ROWS[r][4];
      t_pend[PIN_A] = ROWS[r][3];
      t_vec[PIN_A]  = ROWS[r][2] ? VEC : 8'h32;
      sw_write(PIN_A);
      run_eoi(VEC);
      check(hs_ok, "R2 handshake and index walk", int'(hs_ok), 1);
      check(clr_hit[PIN_A] == ROWS[r][1], "R4 clear strobe", int'(clr_hit[PIN_A]), int'(ROWS[r][1]));
      check(hit[PIN_A + 1] == ROWS[r][0], "R5 immediate pulse", int'(hit[PIN_A + 1]), int'(ROWS[r][0]));
      check(pulse_count() == int'(ROWS[r][0]), "R6 no other request", pulse_count(), int'(ROWS[r][0]));
      for (int p = 0; p < NP; p++)
        if (p != PIN_A)
          check(t_rirr[p] == 1'b1 && !clr_hit[p], "R3 non-matching untouched", int'(t_rirr[p]), 1);
    end

    // counter history on PIN_A
    table_default();
    t_vec[PIN_A] = VEC;
    sw_write(PIN_A);
    for (int e = 0; e < 2; e++) begin
      t_rirr[PIN_A] = 1'b1;
      run_eoi(VEC);
      check(hit[PIN_A + 1] && pulse_count() == 1, "R5 consecutive immediate", pulse_count(), 1);
    end
    t_rirr[PIN_A] = 1'b1;
    run_eoi(VEC);
    check(!hit[PIN_A + 1], "R7 no immediate at threshold", int'(hit[PIN_A + 1]), 0);
    check(hit[PIN_A + 1 + DLY] && pulse_count() == 1, "R7 delayed pulse", pulse_count(), 1);

    for (int e = 0; e < 2; e++) begin
      t_rirr[PIN_A] = 1'b1;
      run_eoi(VEC);
      check(hit[PIN_A + 1] && pulse_count() == 1, "R7 count restarted", pulse_count(), 1);
    end
    t_rirr[PIN_A] = 1'b1; t_msk[PIN_A] = 1'b1;
    run_eoi(VEC);
    check(pulse_count() == 0, "R6 masked release", pulse_count(), 0);
    t_msk[PIN_A] = 1'b0;
    for (int e = 0; e < 2; e++) begin
      t_rirr[PIN_A] = 1'b1;
      run_eoi(VEC);
      check(hit[PIN_A + 1] && pulse_count() == 1, "R6 count was cleared", pulse_count(), 1);
    end
    sw_write(PIN_A);
    for (int e = 0; e < 2; e++) begin
      t_rirr[PIN_A] = 1'b1;
      run_eoi(VEC);
      check(hit[PIN_A + 1] && pulse_count() == 1, "R8 write cleared count", pulse_count(), 1);
    end

    // PIN_A count is now 2; flag clear leaves it alone while PIN_B advances
    t_vec[PIN_B] = VEC;
    sw_write(PIN_B);
    for (int e = 0; e < 2; e++) begin
      t_rirr[PIN_A] = 1'b0; t_rirr[PIN_B] = 1'b1;
      run_eoi(VEC);
      check(!clr_hit[PIN_A] && hit[PIN_B + 1] && pulse_count() == 1, "R4 flag-clear entry skipped",
            pulse_count(), 1);
    end
    t_rirr[PIN_A] = 1'b1; t_rirr[PIN_B] = 1'b1;
    run_eoi(VEC);
    check(hit[PIN_A + 1 + DLY], "R4 count kept so pin throttles", int'(hit[PIN_A + 1 + DLY]), 1);
    check(!hit[PIN_B + 1 + DLY] && pulse_count() == 1, "R9 second throttle absorbed", pulse_count(), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule